// File: doc/BRIEF.md
# USB Device Interrupt Status and Mask Unit

This block keeps the interrupt status word and the interrupt-enable half of the control word of a USB device controller. Single-cycle event strobes from the surrounding controller (DMA overrun or underrun, error, wakeup, suspend, bus reset, start-of-frame, missed start-of-frame) are caught in sticky flags. Software clears them by writing zero to the flag's position. The correct-transfer flag is not stored here. It is the OR of the per-endpoint pending inputs. The status word also reports the lowest pending endpoint and the direction of its transfer.

The control word holds one enable bit per status flag, at the same position as that flag, plus five low-order power and bus control bits that leave the block as outputs. A single interrupt request is asserted whenever any enabled flag is set. The CPU reaches both words through a one-bit-addressed register port: writes take effect on the clock edge, and reads are combinational.

Top module: `usbirq_unit`

## Requirements
- R1: After reset the status word reads 0x0000 when no endpoint is pending, the control word reads 0x0003, and `irq` is 0.
- R2: A pulse on `evt_strobe[i]` (i = 0..6) sets status bit 8+i at the next clock edge, and the bit stays set after the pulse ends. The bit positions are: 14 DMA over/underrun, 13 error, 12 wakeup, 11 suspend, 10 bus reset, 9 start-of-frame, 8 missed start-of-frame.
- R3: A write to the status word (`reg_addr`=0) clears each of bits 14:8 whose data bit is 0. Bits written as 1 keep their value.
- R4: If a strobe and a clearing write hit the same flag in the same cycle, the flag is set after that edge.
- R5: Status bit 15 reads 1 exactly when any bit of `ep_rx_pend` or `ep_tx_pend` is 1. Writing the status word cannot change it.
- R6: Status bits 3:0 give the lowest endpoint index whose receive or transmit pending bit is set. Bit 4 is that endpoint's receive pending bit. Both fields read 0 when nothing is pending, and writes do not affect them.
- R7: The control word (`reg_addr`=1) stores written bits 15:8 and 4:0 and returns them on read. Bits 7:5 of both words read 0, and writing one word leaves the other unchanged.
- R8: The outputs `ctl_resume`, `ctl_force_susp`, `ctl_low_power`, `ctl_power_down` and `ctl_force_reset` follow control bits 4, 3, 2, 1 and 0, starting at the edge of the write.
- R9: `irq` is 1 exactly when, for some n in 8..15, status bit n and control bit n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 7 | Event pulses; bit i sets status bit 8+i |
| ep_rx_pend | input | NUM_EP | Per-endpoint receive transfer pending |
| ep_tx_pend | input | NUM_EP | Per-endpoint transmit transfer pending |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 1 | 0 selects status, 1 selects control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| ctl_force_reset | output | 1 | Control bit 0 |
| ctl_power_down | output | 1 | Control bit 1 |
| ctl_low_power | output | 1 | Control bit 2 |
| ctl_force_susp | output | 1 | Control bit 3 |
| ctl_resume | output | 1 | Control bit 4 |

## Verification
Flags, control bits and the control outputs change one edge after the strobe or write that causes them. The bench drives each stimulus 1 ns after a rising edge and reads the result 1 ns after the following rising edge. The correct-transfer bit, the endpoint and direction fields, `reg_rdata` and `irq` are combinational from the pending inputs and the stored state. They are therefore sampled within the same cycle, 1 ns after the inputs or the read address settle, with no edge in between. The sweep covers all 256 receive-pending patterns, and for several flag patterns it checks every one of the 256 mask values.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   localparam int REG_W     = 16;
   localparam int EVT_N     = 7;
   localparam int EVT_LSB   = 8;
   localparam int CTR_BIT   = 15;
   localparam int DIR_BIT   = 4;
   localparam int ID_W      = 4;
   localparam int CTL_LOW_W = 5;
   localparam int MASK_W    = EVT_N + 1;
   localparam logic [REG_W-1:0] CTL_RST = 16'h0003;

   typedef enum logic {
      SEL_STATUS  = 1'b0,
      SEL_CONTROL = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/usbirq_evt_flags.sv
module usbirq_evt_flags #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_data,
   output logic [N-1:0] flags
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[g] <= 1'b0;
         else if (strobe[g])
            flags[g] <= 1'b1;
         else if (clr_wr && !clr_data[g])
            flags[g] <= 1'b0;
      end

      assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         strobe[g] |=> flags[g]);
      assert_evt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && !clr_data[g] && !strobe[g]) |=> !flags[g]);
      assert_evt_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && clr_data[g] && flags[g]) |=> flags[g]);
      assert_evt_race_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && !clr_data[g] && strobe[g]) |=> flags[g]);
   end
endmodule

// File: rtl/usbirq_ep_prio.sv
module usbirq_ep_prio #(
   parameter int NUM_EP = 8,
   parameter int ID_W   = 4
) (
   input  logic [NUM_EP-1:0] rx_pend,
   input  logic [NUM_EP-1:0] tx_pend,
   output logic              any,
   output logic [ID_W-1:0]   idx,
   output logic              dir
);
   logic [NUM_EP-1:0] pend;

   always_comb begin
      pend = rx_pend | tx_pend;
      any  = |pend;
      idx  = '0;
      dir  = 1'b0;
      for (int k = NUM_EP - 1; k >= 0; k--) begin
         if (pend[k]) begin
            idx = ID_W'(k);
            dir = rx_pend[k];
         end
      end
   end
endmodule

// File: rtl/usbirq_ctl_reg.sv
module usbirq_ctl_reg #(
   parameter int               REG_W   = 16,
   parameter int               MASK_W  = 8,
   parameter int               LOW_W   = 5,
   parameter logic [REG_W-1:0] RST_VAL = 16'h0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output logic [MASK_W-1:0] mask,
   output logic [LOW_W-1:0]  low
);
   localparam int MASK_LSB = REG_W - MASK_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= RST_VAL[REG_W-1:MASK_LSB];
         low  <= RST_VAL[LOW_W-1:0];
      end else if (wr) begin
         mask <= wdata[REG_W-1:MASK_LSB];
         low  <= wdata[LOW_W-1:0];
      end
   end

   assert_ctl_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> mask == $past(wdata[REG_W-1:MASK_LSB]));
   assert_ctl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> low == $past(wdata[LOW_W-1:0]));
   assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mask) && $stable(low));
endmodule

// File: rtl/usbirq_unit.sv
module usbirq_unit
   import usbirq_pkg::*;
#(
   parameter int NUM_EP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_N-1:0]  evt_strobe,
   input  logic [NUM_EP-1:0] ep_rx_pend,
   input  logic [NUM_EP-1:0] ep_tx_pend,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq,
   output logic              ctl_force_reset,
   output logic              ctl_power_down,
   output logic              ctl_low_power,
   output logic              ctl_force_susp,
   output logic              ctl_resume
);
   localparam int GAP_W = DIR_BIT - ID_W;
   localparam int MID_W = EVT_LSB - DIR_BIT - 1;

   if (NUM_EP < 1 || NUM_EP > (1 << ID_W)) begin : g_bad_ep
      $error("usbirq_unit: NUM_EP must lie in 1..16");
   end
   if (GAP_W != 0 || MID_W != 3) begin : g_bad_layout
      $error("usbirq_unit: status field layout mismatch");
   end

   reg_sel_e             sel;
   logic                 wr_stat, wr_ctl;
   logic [EVT_N-1:0]     flags;
   logic                 ctr_any, ep_dir;
   logic [ID_W-1:0]      ep_idx;
   logic [MASK_W-1:0]    mask;
   logic [CTL_LOW_W-1:0] low;
   logic [REG_W-1:0]     status_w, control_w;

   assign sel     = reg_sel_e'(reg_addr);
   assign wr_stat = reg_wr && (sel == SEL_STATUS);
   assign wr_ctl  = reg_wr && (sel == SEL_CONTROL);

   usbirq_evt_flags #(.N(EVT_N)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (evt_strobe),
      .clr_wr   (wr_stat),
      .clr_data (reg_wdata[EVT_LSB +: EVT_N]),
      .flags    (flags)
   );

   usbirq_ep_prio #(.NUM_EP(NUM_EP), .ID_W(ID_W)) u_prio (
      .rx_pend (ep_rx_pend),
      .tx_pend (ep_tx_pend),
      .any     (ctr_any),
      .idx     (ep_idx),
      .dir     (ep_dir)
   );

   usbirq_ctl_reg #(
      .REG_W   (REG_W),
      .MASK_W  (MASK_W),
      .LOW_W   (CTL_LOW_W),
      .RST_VAL (CTL_RST)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctl),
      .wdata (reg_wdata),
      .mask  (mask),
      .low   (low)
   );

   assign status_w  = {ctr_any, flags, {MID_W{1'b0}}, ep_dir, ep_idx};
   assign control_w = {mask, {MID_W{1'b0}}, low};
   assign reg_rdata = (sel == SEL_CONTROL) ? control_w : status_w;
   assign irq       = |({ctr_any, flags} & mask);

   assign ctl_force_reset = low[0];
   assign ctl_power_down  = low[1];
   assign ctl_low_power   = low[2];
   assign ctl_force_susp  = low[3];
   assign ctl_resume      = low[4];

   assert_ctr_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ep_rx_pend | ep_tx_pend) && mask[MASK_W-1]) |-> irq);
   assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|mask));
   assert_ep_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ep_rx_pend | ep_tx_pend)) |->
         ((ep_rx_pend[ep_idx] | ep_tx_pend[ep_idx]) && ep_dir == ep_rx_pend[ep_idx]));
   assert_ep_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(ep_rx_pend | ep_tx_pend)) |-> (ep_idx == '0 && !ep_dir));
endmodule

// File: tb/sim_usbirq_unit.sv
`timescale 1ns/1ps
module sim_usbirq_unit;
   localparam int NEP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evt_strobe = '0;
   logic [NEP-1:0] ep_rx_pend = '0, ep_tx_pend = '0;
   logic        reg_wr = 1'b0, reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq, ctl_force_reset, ctl_power_down, ctl_low_power, ctl_force_susp, ctl_resume;

   int vecs = 0, bad = 0;
   logic [6:0] exp_f;

   usbirq_unit #(.NUM_EP(NEP)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
      .ep_rx_pend(ep_rx_pend), .ep_tx_pend(ep_tx_pend),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq),
      .ctl_force_reset(ctl_force_reset), .ctl_power_down(ctl_power_down),
      .ctl_low_power(ctl_low_power), .ctl_force_susp(ctl_force_susp),
      .ctl_resume(ctl_resume)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [15:0] ep_field(input logic [NEP-1:0] rx, input logic [NEP-1:0] tx);
      logic [NEP-1:0] p;
      p = rx | tx;
      ep_field = '0;
      for (int k = NEP - 1; k >= 0; k--)
         if (p[k]) ep_field = {(p != 0), 10'b0, rx[k], 4'(k)};
   endfunction

   initial begin
      #500us;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      #7 rst_n = 1'b1;
      step();
      // R1 reset state
      rd(1'b0, d); check("R1 status", d, 16'h0000);
      rd(1'b1, d); check("R1 control", d, 16'h0003);
      check("R1 irq", {15'b0, irq}, 16'h0000);
      check("R8 reset outputs", {11'b0, ctl_resume, ctl_force_susp, ctl_low_power,
            ctl_power_down, ctl_force_reset}, 16'h0003);

      // R2 each event strobe sets its bit and holds
      exp_f = '0;
      for (int i = 0; i < 7; i++) begin
         evt_strobe = 7'(1 << i);
         step();
         evt_strobe = '0;
         exp_f[i] = 1'b1;
         step();
         rd(1'b0, d); check("R2 event set", d, {1'b0, exp_f, 8'h00});
      end
      // R3 writing ones leaves flags
      wr(1'b0, 16'hFFFF);
      rd(1'b0, d); check("R3 write ones", d, {1'b0, exp_f, 8'h00});
      // R3 clear one flag at a time
      for (int i = 6; i >= 0; i--) begin
         wr(1'b0, ~(16'(1) << (8 + i)));
         exp_f[i] = 1'b0;
         rd(1'b0, d); check("R3 clear one", d, {1'b0, exp_f, 8'h00});
      end
      // R4 strobe beats simultaneous clear
      evt_strobe = 7'b0001000;
      wr(1'b0, 16'h0000);
      evt_strobe = '0;
      rd(1'b0, d); check("R4 race", d, 16'h0800);
      wr(1'b0, 16'h0000);
      rd(1'b0, d); check("R3 clear after race", d, 16'h0000);

      // R5/R6 endpoint sweep
      for (int p = 0; p < 256; p++) begin
         ep_rx_pend = 8'(p);
         ep_tx_pend = 8'((p * 37) ^ (p >> 1)) & 8'(p ? 8'hFF : 8'h00);
         rd(1'b0, d);
         check("R5 R6 endpoint field", d, ep_field(ep_rx_pend, ep_tx_pend));
      end
      ep_rx_pend = 8'h00; ep_tx_pend = 8'h20;
      wr(1'b0, 16'h0000);
      rd(1'b0, d); check("R5 ctr not clearable", d, 16'h8005);
      ep_tx_pend = '0;
      rd(1'b0, d); check("R6 none pending", d, 16'h0000);

      // R7/R8 control register
      wr(1'b1, 16'hFFFF);
      rd(1'b1, d); check("R7 ctl all", d, 16'hFF1F);
      check("R8 outs all", {11'b0, ctl_resume, ctl_force_susp, ctl_low_power,
            ctl_power_down, ctl_force_reset}, 16'h001F);
      wr(1'b1, 16'hA5EA);
      rd(1'b1, d); check("R7 ctl pattern", d, 16'hA50A);
      check("R8 outs pattern", {11'b0, ctl_resume, ctl_force_susp, ctl_low_power,
            ctl_power_down, ctl_force_reset}, 16'h000A);
      wr(1'b0, 16'h00E0);
      rd(1'b1, d); check("R7 ctl untouched by status write", d, 16'hA50A);
      rd(1'b0, d); check("R7 status reserved zero", d, 16'h0000);

      // R9 mask sweep over several flag patterns
      for (int q = 0; q < 4; q++) begin
         logic [7:0] fp;
         fp = (q == 0) ? 8'h01 : (q == 1) ? 8'h40 : (q == 2) ? 8'h80 : 8'hAA;
         wr(1'b0, 16'h0000);
         ep_rx_pend = fp[7] ? 8'h04 : 8'h00;
         evt_strobe = fp[6:0];
         step();
         evt_strobe = '0;
         for (int m = 0; m < 256; m++) begin
            wr(1'b1, {8'(m), 8'h00});
            check("R9 irq", {15'b0, irq}, {15'b0, |(fp & 8'(m))});
         end
      end
      ep_rx_pend = '0;

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule